// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block resolves a translation once the TLB has missed. It takes a 52-bit virtual page number made of a 40-bit segment ID and a 12-bit page field. It folds the VPN into a group index and walks the page-table entries of that group through a synchronous read port, one read per cycle. The walk stops at the first live entry whose tag equals the VPN. When the primary group holds no match, the block walks a secondary group at a complementary index. It then reports either a hit, with the real page number and the memory-access attribute bits, or a miss that the caller turns into a page fault.

On a hit the block writes the matched entry back to the same address with its reference bit set, so replacement software can see which pages were used recently. The TLB side uses a valid/ready request and a single-cycle response pulse. Only one lookup is in flight at a time.

Top module: `ptw_group_search`

## Requirements
- R1: After reset, req_ready is 1, and resp_valid, mem_rd_en and mem_wr_en are 0.
- R2: With page = vpn[11:0] and seg = vpn[51:12], the primary group index is page[HASH_W-1:0] XOR seg[HASH_W-1:0]. The entry address is {group index, slot}. Slots 0 to GROUP_SLOTS-1 are read in ascending order, one per cycle, and the first read is issued in the cycle after the request is accepted.
- R3: A 128-bit entry is laid out as tag [127:71], live bit [70], real page number [69:30], reference [29], change [28], write-through [27], cache-inhibit [26], coherence [25], guarded [24] and unused [23:0]. An entry matches when its live bit is 1 and tag bits [51:0] equal the VPN. Tag bits [56:52] are ignored.
- R4: A hit returns resp_hit=1 together with the real page number and resp_attr = {write-through, cache-inhibit, coherence, guarded} of the lowest-ordered matching entry. Entries after it are never read.
- R5: After a primary miss, the group at the bitwise complement of the primary index is read from slot 0 upward. resp_secondary is 1 exactly when the hit came from that group.
- R6: When neither group matches, the block makes exactly 2*GROUP_SLOTS reads and then gives resp_hit=0, resp_rpn=0, and no write.
- R7: If the match is at read position k (0-based, secondary slots counting from GROUP_SLOTS), resp_valid rises k+2 cycles after the accepting edge. A full miss answers after 2*GROUP_SLOTS+1 cycles.
- R8: A hit causes exactly one write, to the matched address, in the same cycle as resp_valid. The data is the read entry with only bit 29 forced to 1. No read occurs in that cycle.
- R9: req_ready is 0 from acceptance until resp_valid has been shown. Requests offered in that window are ignored. resp_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_vpn | input | 52 | Virtual page number {segment, page} |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_hit | output | 1 | 1 = translation found, 0 = page fault |
| resp_secondary | output | 1 | Hit came from the complementary group |
| resp_rpn | output | 40 | Real page number of the hit |
| resp_attr | output | 4 | {write-through, cache-inhibit, coherence, guarded} |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | HASH_W+3 | Table read address {group, slot} |
| mem_rd_data | input | 128 | Entry, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Reference-bit write-back strobe |
| mem_wr_addr | output | HASH_W+3 | Write-back address |
| mem_wr_data | output | 128 | Write-back entry |

## Verification
The result of a lookup is due k+2 cycles after the accepting edge, where k is the read position of the match. A full miss is due at 17 cycles. The bench counts cycles from acceptance and compares that count with k+2, so a response that comes early or late fails even when its data is right. It samples every output on the falling edge. It waits one more edge after resp_valid before it inspects the write that its table model has captured. It also replays the exact order of read addresses against the hash it computes itself.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, the entry layout and the sequencer state type
// for the page-table group search. The entry layout is fixed: the
// tag sits in the top bits and the attribute bits sit just above the unused field.
package ptw_pkg;

    localparam int SEG_W  = 40;
    localparam int PAGE_W = 12;
    localparam int VPN_W  = SEG_W + PAGE_W;
    localparam int TAG_W  = 57;
    localparam int RPN_W  = 40;
    localparam int ATTR_W = 4;
    localparam int RSVD_W = 24;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             live;
        logic [RPN_W-1:0] rpn;
        logic             ref_bit;
        logic             chg_bit;
        logic             wr_thru;
        logic             cache_inh;
        logic             coherent;
        logic             guarded;
        logic [RSVD_W-1:0] rsvd;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_RESP   = 2'd2
    } walk_state_e;

endpackage

// File: rtl/ptw_hash.sv
`timescale 1ns/1ps
// Module: ptw_hash
// Folds the low bits of the page field and the segment ID into the
// primary group index. The secondary index is its bitwise complement.
// Assumes the caller passes only the HASH_W low bits of each field.
module ptw_hash #(
    parameter int HASH_W = 10
) (
    input  logic [HASH_W-1:0] page_lo,
    input  logic [HASH_W-1:0] seg_lo,
    output logic [HASH_W-1:0] idx_pri,
    output logic [HASH_W-1:0] idx_sec
);

    // One XOR per index bit; the complement gives the overflow group
    for (genvar b = 0; b < HASH_W; b++) begin : g_bit
        assign idx_pri[b] = page_lo[b] ^ seg_lo[b];
        assign idx_sec[b] = ~(page_lo[b] ^ seg_lo[b]);
    end

endmodule

// File: rtl/ptw_match.sv
`timescale 1ns/1ps
// Module: ptw_match
// Decides whether one entry translates the requested VPN. Only the low
// VPN_W tag bits take part; the upper tag bits are ignored.
module ptw_match
    import ptw_pkg::*;
(
    input  pte_t             entry,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit
);

    // Live entry with matching low tag bits
    always_comb begin
        hit = entry.live && (entry.tag[VPN_W-1:0] == vpn);
    end

endmodule

// File: rtl/ptw_seq.sv
`timescale 1ns/1ps
// Module: ptw_seq
// Sequencer for one walk. It issues reads for positions 0 to 2*GROUP_SLOTS-1
// back to back, tracks which position's data is in the compare stage,
// and ends the walk on the first compare hit or after the last compare.
// Assumes the read data returns exactly one cycle after the read strobe
// and that GROUP_SLOTS is a power of two.
module ptw_seq
    import ptw_pkg::*;
#(
    parameter int GROUP_SLOTS = 8,
    localparam int SLOT_W = $clog2(GROUP_SLOTS),
    localparam int IDX_W  = SLOT_W + 1,
    localparam int LAST   = 2 * GROUP_SLOTS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hit,
    output logic             busy,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             cmp_valid,
    output logic [IDX_W-1:0] cmp_idx,
    output logic             finish_hit,
    output logic             finish_miss
);

    walk_state_e      state;
    logic [IDX_W-1:0] issue_idx;
    logic             issue_done;
    logic             cmp_valid_q;
    logic [IDX_W-1:0] cmp_idx_q;

    // Strobes and walk-end decode from the state and compare stage
    always_comb begin
        busy        = (state != ST_IDLE);
        cmp_valid   = (state == ST_SEARCH) && cmp_valid_q;
        rd_en       = (state == ST_SEARCH) && !issue_done && !cmp_hit;
        finish_hit  = (state == ST_SEARCH) && cmp_hit;
        finish_miss = cmp_valid && !cmp_hit && (cmp_idx_q == IDX_W'(LAST));
        rd_idx      = issue_idx;
        cmp_idx     = cmp_idx_q;
    end

    // Walk state, read counter and compare-stage tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            issue_idx   <= '0;
            issue_done  <= 1'b0;
            cmp_valid_q <= 1'b0;
            cmp_idx_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_SEARCH;
                        issue_idx   <= '0;
                        issue_done  <= 1'b0;
                        cmp_valid_q <= 1'b0;
                    end
                end
                ST_SEARCH: begin
                    cmp_valid_q <= rd_en;
                    cmp_idx_q   <= issue_idx;
                    if (rd_en) begin
                        issue_idx <= issue_idx + 1'b1;
                        if (issue_idx == IDX_W'(LAST)) begin
                            issue_done <= 1'b1;
                        end
                    end
                    if (finish_hit || finish_miss) begin
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state       <= ST_IDLE;
                    cmp_valid_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptw_group_search.sv
`timescale 1ns/1ps
// Module: ptw_group_search (top)
// Hashed page-table group search. It accepts one VPN, walks the primary
// group and then the complementary group through a synchronous read port,
// and returns hit or miss as a one-cycle response. On a hit it writes
// the entry back with its reference bit set.
// Assumes a read latency of one cycle and a table of 2**HASH_W groups,
// each with GROUP_SLOTS entries (a power of two).
module ptw_group_search
    import ptw_pkg::*;
#(
    parameter int HASH_W      = 10,
    parameter int GROUP_SLOTS = 8,
    localparam int SLOT_W = $clog2(GROUP_SLOTS),
    localparam int IDX_W  = SLOT_W + 1,
    localparam int ADDR_W = HASH_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_secondary,
    output logic [RPN_W-1:0]  resp_rpn,
    output logic [ATTR_W-1:0] resp_attr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [PTE_W-1:0]  mem_wr_data
);

    logic [VPN_W-1:0]  vpn_q;
    logic [HASH_W-1:0] idx_pri;
    logic [HASH_W-1:0] idx_sec;
    logic              busy;
    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic              cmp_valid;
    logic [IDX_W-1:0]  cmp_idx;
    logic              entry_hit;
    logic              cmp_hit;
    logic              finish_hit;
    logic              finish_miss;
    logic [ADDR_W-1:0] cmp_addr;
    pte_t              rd_entry;

    logic              resp_valid_q;
    logic              hit_q;
    logic              sec_q;
    logic [RPN_W-1:0]  rpn_q;
    logic [ATTR_W-1:0] attr_q;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wb_addr_q;
    pte_t              wb_entry_q;

    ptw_hash #(
        .HASH_W (HASH_W)
    ) u_hash (
        .page_lo (vpn_q[HASH_W-1:0]),
        .seg_lo  (vpn_q[PAGE_W+HASH_W-1:PAGE_W]),
        .idx_pri (idx_pri),
        .idx_sec (idx_sec)
    );

    ptw_seq #(
        .GROUP_SLOTS (GROUP_SLOTS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_valid && !busy),
        .cmp_hit     (cmp_hit),
        .busy        (busy),
        .rd_en       (rd_en),
        .rd_idx      (rd_idx),
        .cmp_valid   (cmp_valid),
        .cmp_idx     (cmp_idx),
        .finish_hit  (finish_hit),
        .finish_miss (finish_miss)
    );

    ptw_match u_match (
        .entry (rd_entry),
        .vpn   (vpn_q),
        .hit   (entry_hit)
    );

    // Read-side address build and compare qualification
    always_comb begin
        rd_entry    = pte_t'(mem_rd_data);
        cmp_hit     = cmp_valid && entry_hit;
        mem_rd_en   = rd_en;
        mem_rd_addr = {(rd_idx[SLOT_W] ? idx_sec : idx_pri), rd_idx[SLOT_W-1:0]};
        cmp_addr    = {(cmp_idx[SLOT_W] ? idx_sec : idx_pri), cmp_idx[SLOT_W-1:0]};
    end

    // Capture the VPN when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
        end else if (req_valid && !busy) begin
            vpn_q <= req_vpn;
        end
    end

    // Register the response and the reference-bit write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            hit_q        <= 1'b0;
            sec_q        <= 1'b0;
            rpn_q        <= '0;
            attr_q       <= '0;
            wr_en_q      <= 1'b0;
            wb_addr_q    <= '0;
            wb_entry_q   <= '0;
        end else begin
            resp_valid_q <= finish_hit || finish_miss;
            wr_en_q      <= finish_hit;
            if (finish_hit) begin
                hit_q              <= 1'b1;
                sec_q              <= cmp_idx[SLOT_W];
                rpn_q              <= rd_entry.rpn;
                attr_q             <= {rd_entry.wr_thru, rd_entry.cache_inh,
                                       rd_entry.coherent, rd_entry.guarded};
                wb_addr_q          <= cmp_addr;
                wb_entry_q         <= rd_entry;
                wb_entry_q.ref_bit <= 1'b1;
            end else if (finish_miss) begin
                hit_q  <= 1'b0;
                sec_q  <= 1'b0;
                rpn_q  <= '0;
                attr_q <= '0;
            end
        end
    end

    // Drive the ports from the registered state
    always_comb begin
        req_ready      = !busy;
        resp_valid     = resp_valid_q;
        resp_hit       = hit_q;
        resp_secondary = sec_q;
        resp_rpn       = rpn_q;
        resp_attr      = attr_q;
        mem_wr_en      = wr_en_q;
        mem_wr_addr    = wb_addr_q;
        mem_wr_data    = wb_entry_q;
    end

endmodule

// File: rtl/ptw_group_search_chk.sv
`timescale 1ns/1ps
// Module: ptw_group_search_chk
// Protocol checks on the ports of ptw_group_search, bound below.
module ptw_group_search_chk #(
    parameter int GROUP_SLOTS = 8,
    localparam int SLOT_W = $clog2(GROUP_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_rd_en,
    input logic [SLOT_W-1:0] rd_slot,
    input logic              mem_wr_en
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R8
    AST_WR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (resp_valid && resp_hit)); // R8
    AST_MISS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> !mem_wr_en); // R6
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || resp_valid) |-> !req_ready); // R9
    AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && rd_slot == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> ((rd_slot - $past(rd_slot)) == SLOT_W'(1))); // R2
    AST_RESP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en))); // R7

endmodule

bind ptw_group_search ptw_group_search_chk #(
    .GROUP_SLOTS (GROUP_SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .mem_rd_en  (mem_rd_en),
    .rd_slot    (mem_rd_addr[SLOT_W-1:0]),
    .mem_wr_en  (mem_wr_en)
);

// File: tb/tb_ptw_group_search.sv
`timescale 1ns/1ps
// Bench: small table (16 groups of 8), sweeps of match position and hash
// inputs, with the expected results computed from the requirements.
module tb_ptw_group_search;
    import ptw_pkg::*;

    localparam int HW = 4;
    localparam int GS = 8;
    localparam int AW = HW + 3;
    localparam int NENT = (1 << HW) * GS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [51:0] req_vpn = '0;
    logic resp_valid, resp_hit, resp_secondary;
    logic [39:0] resp_rpn;
    logic [3:0] resp_attr;
    logic mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [127:0] mem_rd_data = '0;
    logic [127:0] mem_wr_data;

    always #5 clk = ~clk;

    ptw_group_search #(.HASH_W(HW), .GROUP_SLOTS(GS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_secondary(resp_secondary), .resp_rpn(resp_rpn), .resp_attr(resp_attr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Table model with read log and write capture
    logic [127:0] mem [NENT];
    logic [AW-1:0] rd_log [64];
    int rd_n = 0;
    int wr_n = 0;
    logic [AW-1:0] wr_a = '0;
    logic [127:0] wr_d = '0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            rd_log[rd_n % 64] <= mem_rd_addr;
            rd_n <= rd_n + 1;
        end
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_n <= wr_n + 1;
            wr_a <= mem_wr_addr;
            wr_d <= mem_wr_data;
        end
    end

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [51:0] v, input int i);
        logic [HW-1:0] g;
        g = v[HW-1:0] ^ v[12+HW-1:12];
        if (i >= GS) g = ~g;
        return {g, 3'(i % GS)};
    endfunction

    function automatic logic [127:0] mk_pte(input logic [56:0] tag, input logic live,
            input logic [39:0] rpn, input logic chg, input logic [3:0] attr);
        pte_t e;
        e = '0;
        e.tag = tag; e.live = live; e.rpn = rpn; e.chg_bit = chg;
        {e.wr_thru, e.cache_inh, e.coherent, e.guarded} = attr;
        e.rsvd = 24'($urandom);
        return e;
    endfunction

    // Fill both groups of a VPN with entries that must not match
    task automatic fill_bg(input logic [51:0] v);
        for (int j = 0; j < 2 * GS; j++) begin
            mem[exp_addr(v, j)] <= mk_pte({5'($urandom), v ^ (52'd1 << ((j * 3) % 52))},
                                          1'($urandom), 40'($urandom), 1'($urandom),
                                          4'($urandom));
        end
        @(negedge clk);
    endtask

    // Issue one lookup; lat counts negedges from acceptance to resp_valid
    task automatic lookup(input logic [51:0] v, output int lat, output bit hit,
                          output bit sec, output logic [39:0] rpn,
                          output logic [3:0] attr, output int rbase);
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn = v;
        rbase = rd_n;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        hit = resp_hit; sec = resp_secondary; rpn = resp_rpn; attr = resp_attr;
        @(negedge clk);
    endtask

    // Place one match at read position k and check every result of the walk
    task automatic run_hit(input logic [51:0] v, input int k, input logic [4:0] up);
        logic [39:0] rpn_e, rpn;
        logic [3:0] at_e, attr;
        logic [127:0] ent;
        int lat, rbase, wbase;
        bit hit, sec, ok;
        fill_bg(v);
        rpn_e = 40'({$urandom, $urandom});
        at_e = 4'($urandom);
        ent = mk_pte({up, v}, 1'b1, rpn_e, 1'($urandom), at_e);
        mem[exp_addr(v, k)] <= ent;
        @(negedge clk);
        wbase = wr_n;
        lookup(v, lat, hit, sec, rpn, attr, rbase);
        check(hit == 1'b1, "R3 hit on live matching tag", 128'(hit), 128'd1);
        check(lat == k + 2, "R7 hit latency", 128'(lat), 128'(k + 2));
        check(rpn == rpn_e, "R4 real page number", 128'(rpn), 128'(rpn_e));
        check(attr == at_e, "R4 attribute bits", 128'(attr), 128'(at_e));
        check(sec == (k >= GS), "R5 secondary flag", 128'(sec), 128'(k >= GS));
        check(rd_n - rbase == k + 1, "R4 read count stops at match", 128'(rd_n - rbase),
              128'(k + 1));
        ok = 1'b1;
        for (int i = 0; i <= k && i < 64; i++) begin
            if (rd_log[(rbase + i) % 64] != exp_addr(v, i)) ok = 1'b0;
        end
        check(ok, "R2 R5 read address order", 128'(rd_log[(rbase + k) % 64]),
              128'(exp_addr(v, k)));
        check(wr_n - wbase == 1, "R8 one write-back", 128'(wr_n - wbase), 128'd1);
        check(wr_a == exp_addr(v, k), "R8 write-back address", 128'(wr_a),
              128'(exp_addr(v, k)));
        check(wr_d == (ent | (128'd1 << 29)), "R8 write-back data", wr_d,
              ent | (128'd1 << 29));
        check(req_ready == 1'b1, "R9 ready after response", 128'(req_ready), 128'd1);
    endtask

    initial begin : watchdog
        #1_000_000;
        nfail++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [51:0] v, v2;
        logic [39:0] rpn, rpn_a;
        logic [3:0] attr;
        int lat, rbase, wbase, n, extra;
        bit hit, sec, ok, rdy_ok;

        for (int i = 0; i < NENT; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_en == 1'b0 &&
              mem_wr_en == 1'b0, "R1 reset state",
              128'({req_ready, resp_valid, mem_rd_en, mem_wr_en}), 128'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        // Every read position in both groups
        for (int k = 0; k < 2 * GS; k++) begin
            v = 52'({$urandom, $urandom});
            run_hit(v, k, 5'($urandom));
        end

        // Upper tag bits all set must still match (R3)
        run_hit(52'h0_1234_5678_9ABC, 3, 5'h1F);

        // Full miss: dead exact tags and live near tags (R3, R6)
        v = 52'h3_C0DE_0000_F00D;
        for (int j = 0; j < 2 * GS; j++) begin
            if (j % 2 == 0)
                mem[exp_addr(v, j)] <= mk_pte({5'd0, v}, 1'b0, 40'hABC, 1'b0, 4'hF);
            else
                mem[exp_addr(v, j)] <= mk_pte({5'd0, v ^ (52'd1 << (j * 3))}, 1'b1,
                                              40'hABC, 1'b0, 4'hF);
        end
        @(negedge clk);
        wbase = wr_n;
        lookup(v, lat, hit, sec, rpn, attr, rbase);
        check(hit == 1'b0, "R6 miss reported", 128'(hit), 128'd0);
        check(rpn == 40'd0, "R6 miss page number zero", 128'(rpn), 128'd0);
        check(lat == 2 * GS + 1, "R7 miss latency", 128'(lat), 128'(2 * GS + 1));
        check(rd_n - rbase == 2 * GS, "R6 reads on miss", 128'(rd_n - rbase), 128'(2 * GS));
        ok = 1'b1;
        for (int i = 0; i < 2 * GS; i++)
            if (rd_log[(rbase + i) % 64] != exp_addr(v, i)) ok = 1'b0;
        check(ok, "R5 secondary group order on miss", 128'(ok), 128'd1);
        check(wr_n == wbase, "R6 no write on miss", 128'(wr_n - wbase), 128'd0);

        // Lowest slot wins among several matches (R4)
        v = 52'h5_5555_AAAA_1234;
        fill_bg(v);
        mem[exp_addr(v, 2)] <= mk_pte({5'd0, v}, 1'b1, 40'h22, 1'b0, 4'h2);
        mem[exp_addr(v, 5)] <= mk_pte({5'd0, v}, 1'b1, 40'h55, 1'b0, 4'h5);
        mem[exp_addr(v, GS)] <= mk_pte({5'd0, v}, 1'b1, 40'h88, 1'b0, 4'h8);
        @(negedge clk);
        lookup(v, lat, hit, sec, rpn, attr, rbase);
        check(rpn == 40'h22 && lat == 4, "R4 first match wins", 128'(rpn), 128'h22);

        // Request offered while busy is ignored (R9)
        v = 52'h1_2345_6789_ABCD;
        v2 = 52'h0_0000_0000_0007;
        fill_bg(v);
        fill_bg(v2);
        rpn_a = 40'h12_3456_789A;
        mem[exp_addr(v, 6)] <= mk_pte({5'd0, v}, 1'b1, rpn_a, 1'b0, 4'h3);
        mem[exp_addr(v2, 0)] <= mk_pte({5'd0, v2}, 1'b1, 40'h77, 1'b0, 4'h1);
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn = v;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        rdy_ok = 1'b1;
        while (!resp_valid && n < 40) begin
            if (n >= 1 && n <= 4) begin
                req_valid = 1'b1;
                req_vpn = v2;
                if (req_ready) rdy_ok = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(rdy_ok, "R9 not ready while busy", 128'(rdy_ok), 128'd1);
        check(n == 8 && resp_rpn == rpn_a, "R9 busy request ignored", 128'(resp_rpn),
              128'(rpn_a));
        rbase = rd_n;
        extra = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        check(extra == 0 && rd_n == rbase, "R9 no second walk", 128'(extra), 128'd0);

        // Near-exhaustive sweep over the hashed bits of segment and page
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 16; p++) begin
                v = 52'({$urandom, $urandom});
                v[15:12] = 4'(s);
                v[3:0] = 4'(p);
                run_hit(v, int'($urandom % (2 * GS)), 5'($urandom));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule